// File: doc/BRIEF.md
# JTAG Debug Memory-Access Bridge

This block lets an external debug host read and write any location on an on-chip system bus through a JTAG data register. It needs no software and no user resources on the chip. The TAP controller decodes the instruction and, on each Update-DR, presents the shifted data register word together with a strobe. The bridge turns that into a single-master bus transfer (address, write data, byte enables, write flag, request) and finishes it when the bus signals ready, optionally with an error. Read data and two status flags are presented for the next Capture-DR.

Transfers can be single or block. A block word transfer advances the held address by one word when it completes, so a host can stream a buffer with one Update-DR per word. Writes may be byte, half-word or word wide. A dedicated half-word read reaches 16-bit-only registers without a bus error. Any access can be armed to wait for an external trace trigger. That trigger is synchronised into the bridge clock, and its rising edge releases the pending request.

Top module: `jtag_mem_bridge`

## Requirements
- R1: After reset `cap_o` is zero (busy = bit 33, error = bit 32, data = bits 31:0), `bus_req_o` is low and `bus_addr_o` is zero.
- R2: Opcode 1 (load address) copies the low bits of `dr_i` into the held address, and that address is driven on `bus_addr_o` from the next cycle.
- R3: Opcode 2 (word write) issues one bus write with `bus_be_o` = 4'hF and `bus_wdata_o` = `dr_i`. Request, address and write flag stay stable until `bus_rdy_i`.
- R4: Opcode 4 (byte write) drives `bus_be_o` = 1 << addr[1:0] and replicates `dr_i[7:0]` on all four lanes. Opcode 3 (half-word write) drives `bus_be_o` = 4'b0011 << (2*addr[1]) and replicates `dr_i[15:0]` on both halves.
- R5: Opcode 5 (word read) issues a bus read with `bus_be_o` = 4'hF. When it completes without error, the returned word appears in `cap_o[31:0]`.
- R6: Opcode 6 (half-word read) enables only the addressed half (`bus_be_o` = 4'b0011 << (2*addr[1])). It returns that half zero-extended in `cap_o[31:0]`.
- R7: With `blk_i` set, a word read or write that completes without error advances the held address by 4. Without `blk_i`, and for byte or half-word transfers, the address is unchanged.
- R8: A half-word access with addr[0] = 1, or a word access with addr[1:0] != 0, starts no bus cycle and sets the error bit.
- R9: A transfer that completes with `bus_err_i` sets the error bit, leaves `cap_o[31:0]` unchanged and does not advance the address. The error bit stays set until it is cleared.
- R10: The busy bit is high from the accepted command until the bus transfer completes. Any command that arrives while busy, including load address, is ignored.
- R11: When `trig_en_i` is set at the command, no request is raised until a rising edge on `trig_i` has passed the synchroniser. After that edge the transfer proceeds normally.
- R12: Opcode 7 (clear error) clears the error bit when the bridge is idle. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | One-cycle Update-DR strobe |
| op_i | input | 3 | Decoded instruction opcode |
| blk_i | input | 1 | Block-mode bit of the instruction |
| trig_en_i | input | 1 | Hold the access until a trigger arrives |
| dr_i | input | 32 | Shifted data register contents |
| trig_i | input | 1 | Trace trigger from the debug logic (asynchronous) |
| cap_o | output | 34 | Capture word: busy, error, read data |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Write flag |
| bus_addr_o | output | 32 | Bus address (held address) |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_be_o | output | 4 | Byte enables |
| bus_rdy_i | input | 1 | Transfer completes this cycle |
| bus_err_i | input | 1 | Transfer completes with error |
| bus_rdata_i | input | 32 | Read data |

## Verification
The bench builds the bridge with its default 32-bit address and a two-stage trigger synchroniser. A 16-word bus model is placed at the bottom of the address map, and every address at or above 64 answers with a bus error. That small map allows a sweep over all four byte offsets for each access size, aligned and misaligned, and lets a four-word block write be read back as a block. The trigger test issues a second command while the first is held, to show that the hold and the busy-ignore rule both work.

// File: rtl/jbr_pkg.sv
package jbr_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0, OP_SETA = 3'd1, OP_WRW = 3'd2, OP_WRH = 3'd3,
    OP_WRB  = 3'd4, OP_RDW  = 3'd5, OP_RDH = 3'd6, OP_CLRE = 3'd7
  } op_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WTRIG = 2'd1, ST_BUS = 2'd2} st_e;

  function automatic size_e op_size(op_e op);
    case (op)
      OP_WRH, OP_RDH: return SZ_H;
      OP_WRB:         return SZ_B;
      default:        return SZ_W;
    endcase
  endfunction

  function automatic logic is_access(op_e op);
    return (op == OP_WRW) || (op == OP_WRH) || (op == OP_WRB) ||
           (op == OP_RDW) || (op == OP_RDH);
  endfunction

  function automatic logic is_write(op_e op);
    return (op == OP_WRW) || (op == OP_WRH) || (op == OP_WRB);
  endfunction

  function automatic logic misaligned(size_e sz, logic [1:0] a);
    case (sz)
      SZ_H:    return a[0];
      SZ_W:    return a != 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] byte_en(size_e sz, logic [1:0] a);
    case (sz)
      SZ_B:    return LANES'(1) << a;
      SZ_H:    return LANES'(3) << {a[1], 1'b0};
      default: return {LANES{1'b1}};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_data(size_e sz, logic [WORD_W-1:0] d);
    case (sz)
      SZ_B:    return {LANES{d[7:0]}};
      SZ_H:    return {(LANES/2){d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pick_half(logic hi, logic [WORD_W-1:0] r);
    return hi ? {16'd0, r[31:16]} : {16'd0, r[15:0]};
  endfunction
endpackage

// File: rtl/jbr_trig_sync.sv
module jbr_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], trig_i};
  end

  assign pulse_o = sh[STAGES-1] & ~sh[STAGES];

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/jbr_lane.sv
module jbr_lane
  import jbr_pkg::*;
(
  input  size_e             size_i,
  input  logic [1:0]        a_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [WORD_W-1:0] rfmt_o
);
  always_comb begin
    be_o    = byte_en(size_i, a_i);
    wdata_o = lane_data(size_i, data_i);
    rfmt_o  = (size_i == SZ_H) ? pick_half(a_i[1], rdata_i) : rdata_i;
  end
endmodule

// File: rtl/jbr_ctrl.sv
module jbr_ctrl
  import jbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic              blk_i,
  input  logic              trig_en_i,
  input  logic [WORD_W-1:0] dr_i,
  input  logic              trig_pulse_i,
  input  logic              bus_rdy_i,
  input  logic              bus_err_i,
  input  logic [WORD_W-1:0] rfmt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o,
  output size_e             size_o,
  output logic              we_o,
  output logic              req_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES);

  st_e               state;
  logic [ADDR_W-1:0] addr_q;
  logic              blk_q;
  op_e               op;
  logic              cmd_ok, acc, bad, launch, done, step;

  assign op     = op_e'(op_i);
  assign cmd_ok = upd_i && (state == ST_IDLE);
  assign acc    = cmd_ok && is_access(op);
  assign bad    = acc && misaligned(op_size(op), addr_q[1:0]);
  assign launch = acc && !bad;
  assign done   = (state == ST_BUS) && bus_rdy_i;
  assign step   = done && !bus_err_i && blk_q && (size_o == SZ_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      data_o  <= '0;
      size_o  <= SZ_W;
      we_o    <= 1'b0;
      blk_q   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (launch) state <= trig_en_i ? ST_WTRIG : ST_BUS;
        ST_WTRIG: if (trig_pulse_i) state <= ST_BUS;
        ST_BUS:   if (bus_rdy_i) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      if (cmd_ok && op == OP_SETA) addr_q <= dr_i[ADDR_W-1:0];
      else if (step)               addr_q <= addr_q + STEP;
      if (launch) begin
        data_o <= dr_i;
        size_o <= op_size(op);
        we_o   <= is_write(op);
        blk_q  <= blk_i;
      end
      if (cmd_ok && op == OP_CLRE)       err_o <= 1'b0;
      else if (bad || (done && bus_err_i)) err_o <= 1'b1;
      if (done && !bus_err_i && !we_o) rdata_o <= rfmt_i;
    end
  end

  assign addr_o = addr_q;
  assign req_o  = (state == ST_BUS);
  assign busy_o = (state != ST_IDLE);

  a_r10_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> $stable(addr_q));
  a_r8_misaligned_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (err_o && !req_o));
  a_r11_wait_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WTRIG && !trig_pulse_i) |=> !req_o);
  a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !bus_rdy_i) |=> (req_o && $stable(addr_o) && $stable(we_o)));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_err_i) |=> err_o);
endmodule

// File: rtl/jtag_mem_bridge.sv
module jtag_mem_bridge
  import jbr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic              blk_i,
  input  logic              trig_en_i,
  input  logic [WORD_W-1:0] dr_i,
  input  logic              trig_i,
  output logic [WORD_W+1:0] cap_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  output logic [LANES-1:0]  bus_be_o,
  input  logic              bus_rdy_i,
  input  logic              bus_err_i,
  input  logic [WORD_W-1:0] bus_rdata_i
);
  logic              trig_pulse, busy, err;
  logic [WORD_W-1:0] data, rdata, rfmt;
  size_e             size;

  jbr_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .pulse_o(trig_pulse));

  jbr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .op_i(op_i), .blk_i(blk_i),
    .trig_en_i(trig_en_i), .dr_i(dr_i), .trig_pulse_i(trig_pulse),
    .bus_rdy_i(bus_rdy_i), .bus_err_i(bus_err_i), .rfmt_i(rfmt),
    .addr_o(bus_addr_o), .data_o(data), .size_o(size), .we_o(bus_we_o),
    .req_o(bus_req_o), .busy_o(busy), .err_o(err), .rdata_o(rdata));

  jbr_lane i_lane (
    .size_i(size), .a_i(bus_addr_o[1:0]), .data_i(data), .rdata_i(bus_rdata_i),
    .be_o(bus_be_o), .wdata_o(bus_wdata_o), .rfmt_o(rfmt));

  assign cap_o = {busy, err, rdata};

  a_r4_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 ||
                   $countones(bus_be_o) == 4));
endmodule

// File: tb/test_jtag_mem_bridge.sv
module test_jtag_mem_bridge;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, upd = 0, blk = 0, ten = 0, trig = 0;
  logic [2:0]  op = 0;
  logic [31:0] dr = 0;
  logic [33:0] cap;
  logic        req, we, rdy = 0, berr = 0;
  logic [31:0] addr, wdata, rdata = 0;
  logic [3:0]  be;

  int checks = 0, errors = 0, txn = 0;
  logic [31:0] mem [16];
  logic [31:0] l_addr, l_wdata;
  logic [3:0]  l_be;
  logic        l_we;

  always #(CLK_P/2) clk = ~clk;

  jtag_mem_bridge i_jtag_mem_bridge (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .op_i(op), .blk_i(blk),
    .trig_en_i(ten), .dr_i(dr), .trig_i(trig), .cap_o(cap),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_be_o(be), .bus_rdy_i(rdy), .bus_err_i(berr), .bus_rdata_i(rdata));

  // bus model: ready one negedge after request, error at address >= 64
  always @(negedge clk) begin
    if (req && !rdy) begin
      rdy  <= 1'b1;
      berr <= (addr >= 32'd64);
      txn  <= txn + 1;
      l_addr <= addr; l_wdata <= wdata; l_be <= be; l_we <= we;
      if (addr < 32'd64) begin
        rdata <= mem[addr[5:2]];
        if (we)
          for (int b = 0; b < 4; b++)
            if (be[b]) mem[addr[5:2]][8*b +: 8] <= wdata[8*b +: 8];
      end
    end else begin
      rdy <= 1'b0; berr <= 1'b0;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] o, logic b, logic t, logic [31:0] d);
    @(negedge clk);
    op = o; blk = b; ten = t; dr = d; upd = 1;
    @(negedge clk);
    upd = 0; blk = 0; ten = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && cap[33]; i++) @(negedge clk);
    if (cap[33]) chk(0, "watchdog busy", 1, 0);
    @(negedge clk);
  endtask

  task automatic run(logic [2:0] o, logic b, logic [31:0] d);
    cmd(o, b, 0, d);
    wait_idle();
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(0, "watchdog global", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'h0101_0101 * i;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cap == 0, "R1 cap", cap, 0);
    chk(!req && addr == 0, "R1 bus", {req, addr}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 + R3 word write
    run(1, 0, 32'h10);
    chk(addr == 32'h10, "R2 addr", addr, 32'h10);
    run(2, 0, 32'hA5A5_0001);
    chk(l_we && l_be == 4'hF && l_wdata == 32'hA5A5_0001 && l_addr == 32'h10,
        "R3 write", {l_be, l_wdata}, {4'hF, 32'hA5A5_0001});
    chk(mem[4] == 32'hA5A5_0001, "R3 mem", mem[4], 32'hA5A5_0001);

    // R4/R8/R12 sweep: sizes x offsets
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off++) begin
        automatic logic [2:0]  o   = (sz == 0) ? 3'd4 : (sz == 1) ? 3'd3 : 3'd2;
        automatic logic [31:0] d   = 32'hC3D2_E100 + 32'(sz * 16 + off);
        automatic bit          mis = (sz == 1 && off[0]) || (sz == 2 && off != 0);
        automatic logic [3:0]  eb  = (sz == 0) ? 4'(1 << off) :
                                     (sz == 1) ? 4'(3 << (2 * (off / 2))) : 4'hF;
        automatic logic [31:0] ew  = (sz == 0) ? {4{d[7:0]}} :
                                     (sz == 1) ? {2{d[15:0]}} : d;
        automatic int          t0;
        run(1, 0, 32'h18 + 32'(off));
        t0 = txn;
        run(o, 0, d);
        if (mis) begin
          chk(txn == t0 && cap[32], "R8 misaligned", {txn[7:0], cap[32]}, {t0[7:0], 1'b1});
          run(7, 0, 0);
          chk(!cap[32], "R12 clear", cap[32], 0);
        end else begin
          chk(txn == t0 + 1 && l_be == eb && l_wdata == ew && !cap[32],
              "R4 lanes", {l_be, l_wdata}, {eb, ew});
        end
      end
    end

    // R5 word read
    run(1, 0, 32'h24);
    run(5, 0, 0);
    chk(cap[31:0] == mem[9] && l_be == 4'hF, "R5 read", cap[31:0], mem[9]);

    // R6 half-word reads
    for (int off = 0; off < 4; off += 2) begin
      automatic logic [31:0] m = mem[10];
      automatic logic [31:0] e = (off == 2) ? {16'd0, m[31:16]} : {16'd0, m[15:0]};
      run(1, 0, 32'h28 + 32'(off));
      run(6, 0, 0);
      chk(cap[31:0] == e && l_be == 4'(3 << off), "R6 hword", cap[31:0], e);
    end

    // R7 block write then block read, plus non-block word
    run(1, 0, 32'h20);
    for (int k = 0; k < 4; k++) begin
      run(2, 1, 32'hB000_0000 + 32'(k));
      chk(addr == 32'h24 + 32'(4 * k), "R7 advance", addr, 32'h24 + 32'(4 * k));
    end
    run(1, 0, 32'h20);
    for (int k = 0; k < 4; k++) begin
      run(5, 1, 0);
      chk(cap[31:0] == 32'hB000_0000 + 32'(k), "R7 block read", cap[31:0],
          32'hB000_0000 + 32'(k));
    end
    run(5, 0, 0);
    chk(addr == 32'h30, "R7 no advance", addr, 32'h30);
    run(1, 0, 32'h2A);
    run(3, 1, 32'h1234);
    chk(addr == 32'h2A, "R7 hword block", addr, 32'h2A);

    // R9 bus error, R12 clear, opcode 0 no effect
    run(1, 0, 32'h24);
    run(5, 0, 0);
    run(1, 0, 32'h100);
    run(5, 1, 0);
    chk(cap[32] && cap[31:0] == 32'hB000_0001, "R9 err data", cap, {2'b01, 32'hB000_0001});
    chk(addr == 32'h100, "R9 no advance", addr, 32'h100);
    run(0, 0, 0);
    chk(cap[32], "R12 nop keeps err", cap[32], 1);
    run(7, 0, 0);
    chk(!cap[32], "R12 clear", cap[32], 0);

    // R10 + R11 trigger hold with ignored command
    run(1, 0, 32'h08);
    cmd(5, 0, 1, 0);
    cmd(1, 0, 0, 32'h3C);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!req && cap[33], "R11 held", {req, cap[33]}, 2'b01);
    end
    chk(addr == 32'h08, "R10 ignored", addr, 32'h08);
    trig = 1;
    repeat (3) @(negedge clk);
    trig = 0;
    wait_idle();
    chk(!cap[33] && cap[31:0] == mem[2] && l_addr == 32'h08, "R11 released",
        cap[31:0], mem[2]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule